// File: doc/BRIEF.md
# Five-Input Interrupt Priority Controller

This block sits next to a CPU core and accepts five interrupt request lines, each with its own trigger style. When several requests are valid at the same time, it picks the one with the highest fixed priority. It raises a pending flag and holds it until the core answers with a one-cycle take strobe. The four upper sources then receive a fixed 16-bit service address. The lowest-priority, general-purpose source instead gets a one-cycle acknowledge pulse. During that pulse the requesting device places a byte on the external vector bus, and that byte becomes the service address.

Inside, one input stage per source qualifies its line. A priority picker applies the masks and the global enable. A four-state machine runs the handshake:

- **IDLE** waits for a qualified request. It captures the winner and moves to PEND.
- **PEND** holds the pending flag until take. On take it moves to ACK for the general-purpose source and to VECT for all others.
- **ACK** drives the acknowledge pulse, samples the external byte and moves to VECT.
- **VECT** presents the address for one cycle and returns to IDLE.

Every input stage needs two consecutive clock samples, so requests that arrive in the same cycle are compared with each other fairly.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `pending_o`, `gp_ack_o` and `vec_valid_o` are low and the global enable `ie_o` is low.
- R2: Fixed priority from highest to lowest is `irq_nmi_i`, `irq_edge_i`, `irq_lvl_a_i`, `irq_lvl_b_i`, `irq_gp_i`. Among requests that qualify in the same cycle, only the highest one is captured.
- R3: `irq_nmi_i` qualifies only if a low-to-high transition is seen and the line is still high on the next clock sample. A one-cycle pulse is lost. This source is served even when `ie_o` is low, and no mask applies to it.
- R4: A rising edge on `irq_edge_i` is latched, so a one-cycle pulse is still served. The latch clears when that source is taken, and it does not fire again without a new edge.
- R5: `irq_lvl_a_i`, `irq_lvl_b_i` and `irq_gp_i` qualify only when high on two consecutive clock samples. A line that drops earlier is lost.
- R6: `mask_i` bit 0 blocks `irq_edge_i`, bit 1 blocks `irq_lvl_a_i` and bit 2 blocks `irq_lvl_b_i`, where 1 means blocked. When `ie_o` is low, every source except `irq_nmi_i` is blocked.
- R7: The service addresses for the vectored sources are 0x0024 for `irq_nmi_i`, 0x003C for `irq_edge_i`, 0x0034 for `irq_lvl_a_i` and 0x002C for `irq_lvl_b_i`.
- R8: For `irq_gp_i`, take is followed by exactly one cycle of `gp_ack_o`. The byte on `ext_vec_i` during that cycle appears zero-extended on `vec_addr_o` with `vec_valid_o` in the next cycle.
- R9: `pending_o` stays high until `take_i`. Take clears `ie_o`. For a vectored source, `vec_valid_o` is high for exactly one cycle in the cycle after take.
- R10: A one-cycle `ie_set_i` sets `ie_o`. A level source held through a service is served again only after the enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_nmi_i | input | 1 | Top-priority request, edge plus level |
| irq_edge_i | input | 1 | Latched rising-edge request |
| irq_lvl_a_i | input | 1 | Level request A |
| irq_lvl_b_i | input | 1 | Level request B |
| irq_gp_i | input | 1 | General-purpose level request, non-vectored |
| mask_i | input | 3 | Per-source block bits (edge, A, B) |
| ie_set_i | input | 1 | Sets the global enable |
| ext_vec_i | input | 8 | Byte supplied by the device during acknowledge |
| take_i | input | 1 | Core accepts the pending interrupt |
| pending_o | output | 1 | A request has been captured and awaits take |
| gp_ack_o | output | 1 | Acknowledge pulse for the general-purpose source |
| vec_valid_o | output | 1 | Service address is valid this cycle |
| vec_addr_o | output | 16 | Service address |
| ie_o | output | 1 | Global interrupt enable |

## Verification
The bench builds the block with its default widths: a 16-bit address and an 8-bit external byte. With these widths every fixed vector and a byte with its top bit set (0xA5) can be checked exactly on the port. The five-source layout lets the bench set up every pairing that matters for priority, including cases where a higher source is masked so a lower one wins. Single-cycle pulses on each trigger style show which requests are kept and which are lost.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NUM_SRC  = 5;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int NUM_MASK = NUM_SRC - 2;
    localparam int ADDR_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int GP_IDX   = NUM_SRC - 1;

    typedef enum logic [1:0] {
        TRIG_EDGE_LEVEL,
        TRIG_EDGE_HOLD,
        TRIG_LEVEL
    } trig_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_ACK,
        ST_VECT
    } ctl_state_e;

    function automatic trig_e trig_of(input int idx);
        if (idx == 0) return TRIG_EDGE_LEVEL;
        if (idx == 1) return TRIG_EDGE_HOLD;
        return TRIG_LEVEL;
    endfunction

    function automatic logic [ADDR_W-1:0] fixed_vec(input logic [SRC_W-1:0] idx);
        logic [ADDR_W-1:0] v;
        unique case (idx)
            3'd0:    v = ADDR_W'(16'h0024);
            3'd1:    v = ADDR_W'(16'h003C);
            3'd2:    v = ADDR_W'(16'h0034);
            3'd3:    v = ADDR_W'(16'h002C);
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/irq_in_stage.sv
module irq_in_stage
    import irq_prio_pkg::*;
#(
    parameter trig_e MODE = TRIG_LEVEL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= req_i;
    end

    generate
        if (MODE == TRIG_EDGE_LEVEL) begin : g_edge_level
            logic arm_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) arm_q <= 1'b0;
                else        arm_q <= (arm_q & req_i & ~clr_i) | (req_i & ~prev_q);
            end
            assign pend_o = arm_q & req_i;
        end else if (MODE == TRIG_EDGE_HOLD) begin : g_edge_hold
            logic hold_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hold_q <= 1'b0;
                else        hold_q <= (hold_q & ~clr_i) | (req_i & ~prev_q);
            end
            assign pend_o = hold_q;
        end else begin : g_level
            assign pend_o = prev_q & req_i;
        end
    endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_prio_pkg::*;
#(
    parameter int N      = NUM_SRC,
    parameter int IDX_W  = SRC_W,
    parameter int MASK_N = NUM_MASK
) (
    input  logic [N-1:0]      pend_i,
    input  logic              ie_i,
    input  logic [MASK_N-1:0] mask_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [N-1:0] qual;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (i == 0)           qual[i] = pend_i[i];
            else if (i <= MASK_N) qual[i] = pend_i[i] & ie_i & ~mask_i[i-1];
            else                  qual[i] = pend_i[i] & ie_i;
        end
    end

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (qual[i]) idx_o = IDX_W'(i);
        end
        any_o = |qual;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_nmi_i,
    input  logic                irq_edge_i,
    input  logic                irq_lvl_a_i,
    input  logic                irq_lvl_b_i,
    input  logic                irq_gp_i,
    input  logic [NUM_MASK-1:0] mask_i,
    input  logic                ie_set_i,
    input  logic [BW-1:0]       ext_vec_i,
    input  logic                take_i,
    output logic                pending_o,
    output logic                gp_ack_o,
    output logic                vec_valid_o,
    output logic [AW-1:0]       vec_addr_o,
    output logic                ie_o
);
    logic [NUM_SRC-1:0] req_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic               any_req;
    logic [SRC_W-1:0]   pick_idx;
    logic [SRC_W-1:0]   win_q;
    logic [AW-1:0]      addr_q;
    logic               ie_q;
    logic               taken;
    ctl_state_e         state_q, state_d;

    assign req_vec = {irq_gp_i, irq_lvl_b_i, irq_lvl_a_i, irq_edge_i, irq_nmi_i};
    assign taken   = (state_q == ST_PEND) && take_i;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            assign clr_vec[gi] = taken && (win_q == SRC_W'(gi));
            irq_in_stage #(.MODE(trig_of(gi))) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_i  (req_vec[gi]),
                .clr_i  (clr_vec[gi]),
                .pend_o (pend_vec[gi])
            );
        end
    endgenerate

    irq_prio_pick #(.N(NUM_SRC), .IDX_W(SRC_W), .MASK_N(NUM_MASK)) u_pick (
        .pend_i (pend_vec),
        .ie_i   (ie_q),
        .mask_i (mask_i),
        .any_o  (any_req),
        .idx_o  (pick_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_req) state_d = ST_PEND;
            ST_PEND: if (take_i)  state_d = (win_q == SRC_W'(GP_IDX)) ? ST_ACK : ST_VECT;
            ST_ACK:               state_d = ST_VECT;
            ST_VECT:              state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            addr_q <= '0;
            ie_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && any_req) begin
                win_q  <= pick_idx;
                addr_q <= AW'(fixed_vec(pick_idx));
            end
            if (state_q == ST_ACK) addr_q <= AW'(ext_vec_i);
            if (taken)         ie_q <= 1'b0;
            else if (ie_set_i) ie_q <= 1'b1;
        end
    end

    always_comb begin
        pending_o   = 1'b0;
        gp_ack_o    = 1'b0;
        vec_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PEND: pending_o   = 1'b1;
            ST_ACK:  gp_ack_o    = 1'b1;
            ST_VECT: vec_valid_o = 1'b1;
            default: ;
        endcase
        vec_addr_o = addr_q;
        ie_o       = ie_q;
    end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          take_i,
    input logic          pending_o,
    input logic          gp_ack_o,
    input logic          vec_valid_o,
    input logic [AW-1:0] vec_addr_o,
    input logic          ie_o
);
    assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !take_i) |=> pending_o);

    assert_take_clears_ie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && take_i) |=> !ie_o);

    assert_vec_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);

    assert_phase_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pending_o, gp_ack_o, vec_valid_o}));

    assert_ack_then_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gp_ack_o |=> (vec_valid_o && !gp_ack_o));

    assert_take_to_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && take_i) |=> (gp_ack_o || vec_valid_o));

    assert_fixed_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !$past(gp_ack_o)) |->
        (vec_addr_o == AW'(16'h0024) || vec_addr_o == AW'(16'h003C) ||
         vec_addr_o == AW'(16'h0034) || vec_addr_o == AW'(16'h002C)));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_i),
    .pending_o   (pending_o),
    .gp_ack_o    (gp_ack_o),
    .vec_valid_o (vec_valid_o),
    .vec_addr_o  (vec_addr_o),
    .ie_o        (ie_o)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] GP_BYTE = 8'hA5;
    // entry: reqs[26:22] {gp,B,A,edge,nmi}, mask[21:19], ie[18], pend[17], gp[16], vec[15:0]
    localparam int NVEC = 13;
    localparam logic [26:0] TBL [NVEC] = '{
        {5'b00100, 3'b000, 1'b1, 1'b1, 1'b0, 16'h0034},
        {5'b01000, 3'b000, 1'b1, 1'b1, 1'b0, 16'h002C},
        {5'b00010, 3'b000, 1'b1, 1'b1, 1'b0, 16'h003C},
        {5'b00001, 3'b000, 1'b0, 1'b1, 1'b0, 16'h0024},
        {5'b11111, 3'b000, 1'b1, 1'b1, 1'b0, 16'h0024},
        {5'b11110, 3'b000, 1'b1, 1'b1, 1'b0, 16'h003C},
        {5'b11100, 3'b000, 1'b1, 1'b1, 1'b0, 16'h0034},
        {5'b11000, 3'b000, 1'b1, 1'b1, 1'b0, 16'h002C},
        {5'b10000, 3'b000, 1'b1, 1'b1, 1'b1, 16'h00A5},
        {5'b01100, 3'b010, 1'b1, 1'b1, 1'b0, 16'h002C},
        {5'b00100, 3'b010, 1'b1, 1'b0, 1'b0, 16'h0000},
        {5'b11110, 3'b000, 1'b0, 1'b0, 1'b0, 16'h0000},
        {5'b10010, 3'b001, 1'b1, 1'b1, 1'b1, 16'h00A5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi = 1'b0, edg = 1'b0, lva = 1'b0, lvb = 1'b0, gp = 1'b0;
    logic [2:0] mask = '0;
    logic ie_set = 1'b0, take = 1'b0;
    logic [7:0] ext = '0;
    logic pending, gp_ack, vec_valid, ie;
    logic [15:0] vec_addr;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .irq_nmi_i(nmi), .irq_edge_i(edg), .irq_lvl_a_i(lva), .irq_lvl_b_i(lvb), .irq_gp_i(gp),
        .mask_i(mask), .ie_set_i(ie_set), .ext_vec_i(ext), .take_i(take),
        .pending_o(pending), .gp_ack_o(gp_ack), .vec_valid_o(vec_valid),
        .vec_addr_o(vec_addr), .ie_o(ie)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {gp, lvb, lva, edg, nmi} = '0;
        mask = '0; ie_set = 1'b0; take = 1'b0; ext = '0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic enable_ie();
        ie_set = 1'b1;
        tick(1);
        ie_set = 1'b0;
    endtask

    task automatic set_reqs(input logic [4:0] r);
        {gp, lvb, lva, edg, nmi} = r;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 reset outputs", {13'b0, pending, gp_ack, vec_valid}, 16'h0000);
        check("R1 reset enable", {15'b0, ie}, 16'h0000);

        // Table walk: R2 priority, R6 masks/enable, R7 vectors, R8 gp path
        for (int k = 0; k < NVEC; k++) begin
            do_reset();
            mask = TBL[k][21:19];
            if (TBL[k][18]) enable_ie();
            set_reqs(TBL[k][26:22]);
            tick(2);
            check($sformatf("R2/R6 entry %0d pending", k), {15'b0, pending}, {15'b0, TBL[k][17]});
            if (TBL[k][17] && pending) begin
                take = 1'b1;
                tick(1);
                take = 1'b0;
                if (TBL[k][16]) begin
                    check($sformatf("R8 entry %0d ack", k), {15'b0, gp_ack}, 16'h0001);
                    ext = GP_BYTE;
                    tick(1);
                    ext = 8'h00;
                end
                check($sformatf("R7/R8 entry %0d vec", k), {vec_valid, vec_addr[14:0]},
                      {1'b1, TBL[k][14:0]});
            end
        end

        // R3: NMI single-cycle pulse is lost, even with enable off
        do_reset();
        nmi = 1'b1; tick(1); nmi = 1'b0; tick(3);
        check("R3 nmi short pulse lost", {15'b0, pending}, 16'h0000);

        // R5: level A dropped after one sample is lost
        do_reset();
        enable_ie();
        lva = 1'b1; tick(1); lva = 1'b0; tick(3);
        check("R5 level short pulse lost", {15'b0, pending}, 16'h0000);

        // R4: edge pulse latched, served, then not repeated
        do_reset();
        enable_ie();
        edg = 1'b1; tick(1); edg = 1'b0; tick(1);
        check("R4 edge pulse held", {15'b0, pending}, 16'h0001);
        take = 1'b1; tick(1); take = 1'b0;
        check("R4 edge vector", vec_addr, 16'h003C);
        tick(1);
        enable_ie();
        tick(3);
        check("R4 latch cleared", {15'b0, pending}, 16'h0000);

        // R9 / R10: pending held, take clears enable, re-enable re-serves level
        do_reset();
        enable_ie();
        lvb = 1'b1; tick(2);
        tick(5);
        check("R9 pending held", {14'b0, pending, vec_valid}, 16'h0002);
        take = 1'b1; tick(1); take = 1'b0;
        check("R9 vec pulse", {vec_valid, vec_addr[14:0]}, {1'b1, 15'h002C});
        check("R9 enable cleared", {15'b0, ie}, 16'h0000);
        tick(1);
        check("R9 vec one cycle", {15'b0, vec_valid}, 16'h0000);
        tick(3);
        check("R10 no retrigger while disabled", {15'b0, pending}, 16'h0000);
        enable_ie();
        check("R10 enable set", {15'b0, ie}, 16'h0001);
        tick(1);
        check("R10 level served again", {15'b0, pending}, 16'h0001);
        lvb = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule